// File: doc/BRIEF.md
# Write Buffer with Read Bypass

This block sits between a write-through cache and main memory. It takes cache writes in a single cycle into a small FIFO and sends them on to memory in the background, one at a time, oldest first. Writes to the same address are never combined. Each buffered write becomes its own memory write.

A read miss from the cache is compared against every entry still held in the buffer. A static mode input selects the policy. In read-first mode, a read whose address matches a buffered write is answered at once with the data of the youngest matching entry. A read with no match is sent to memory ahead of the queued writes. In drain-first mode, the read waits until the buffer is empty and then reads memory. Only one memory request is outstanding at any time. A memory read blocks further requests until its data comes back.

Top module: `wrbuf_bypass`

## Requirements
- R1: Accepted writes reach the memory port as write requests (`mem_req_we`=1) in the order they were accepted, each with its own address and data.
- R2: Two or more writes to the same address are not merged. Each one produces a separate memory write.
- R3: In read-first mode (`cfg_read_first`=1), a read with no matching entry is issued to memory before every buffered write. The only exception is a write that was already presented and stalled on the memory port, which may go first.
- R4: While the buffer holds DEPTH entries, `wr_ready` is 0.
- R5: In read-first mode, a read whose address matches one or more entries returns the data of the youngest matching entry on `rd_resp_data`, and no memory read is issued.
- R6: In drain-first mode (`cfg_read_first`=0), the memory read for a read miss is issued only after every buffered write has been sent. The response carries the value read from memory.
- R7: From the cycle after a read is accepted until its response, both `wr_ready` and `rd_ready` are 0.
- R8: After a memory read request is accepted, no memory request is presented until `mem_rsp_valid` returns the data.
- R9: A memory request that is not accepted stays presented on the next cycle with the same address and direction.
- R10: After reset the buffer is empty: `wr_ready`=1, `rd_ready`=1, `mem_req_valid`=0, `rd_resp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_read_first | input | 1 | 1: reads check the buffer and may bypass it; 0: reads wait for the buffer to drain |
| wr_valid | input | 1 | Cache write request |
| wr_ready | output | 1 | Buffer can accept a write this cycle |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | DW | Write data |
| rd_valid | input | 1 | Read-miss request |
| rd_ready | output | 1 | Read-miss request can be accepted |
| rd_addr | input | AW | Word address of the read miss |
| rd_resp_valid | output | 1 | One-cycle pulse: read data available |
| rd_resp_data | output | DW | Read data (forwarded or from memory) |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Memory word address |
| mem_req_wdata | output | DW | Memory write data |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_rdata | input | DW | Memory read data |

## Verification
The bench first sends a stream of distinct addresses with memory always ready. This confirms plain FIFO draining in order. A repeated address then shows that entries are not merged. Next, the bench stalls memory until the buffer fills. It then issues a read to an unbuffered address in read-first mode and compares the recorded memory order against one where the read waits. A read to an address written twice while memory stays stalled separates forwarding of the youngest entry from forwarding of the oldest entry, and from a memory read. The same kind of read in drain-first mode must come back only after every write has reached memory.

// File: rtl/wrbuf_pkg.sv
package wrbuf_pkg;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_CHECK,
    RS_DRAIN,
    RS_MEMRD,
    RS_MEMWAIT
  } rd_state_e;

  // slot index of the entry that is 'off' places younger than 'base'
  function automatic int ring_slot(input int base, input int off, input int depth);
    return (base + off) % depth;
  endfunction

endpackage

// File: rtl/wrbuf_store.sv
module wrbuf_store #(
  parameter int DEPTH = 4,
  parameter int AW    = 30,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic [AW-1:0] look_addr,
  output logic          hit,
  output logic [DW-1:0] hit_data,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full
);
  import wrbuf_pkg::*;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] ent_addr [DEPTH];
  logic [DW-1:0] ent_data [DEPTH];
  logic [DEPTH-1:0] ent_vld;
  logic [DEPTH-1:0] match;
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push) begin
        ent_addr[tail_q] <= push_addr;
        ent_data[tail_q] <= push_data;
        ent_vld[tail_q]  <= 1'b1;
        tail_q           <= ptr_inc(tail_q);
      end
      if (pop) begin
        ent_vld[head_q] <= 1'b0;
        head_q          <= ptr_inc(head_q);
      end
      case ({push, pop})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  // per-entry address comparators
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = ent_vld[g] && (ent_addr[g] == look_addr);
  end

  // walk from oldest to youngest; the last match wins
  always_comb begin
    logic [PW-1:0] sidx;
    hit      = 1'b0;
    hit_data = '0;
    for (int off = 0; off < DEPTH; off++) begin
      sidx = PW'(ring_slot(int'(head_q), off, DEPTH));
      if (match[sidx]) begin
        hit      = 1'b1;
        hit_data = ent_data[sidx];
      end
    end
  end

  assign head_addr = ent_addr[head_q];
  assign head_data = ent_data[head_q];
  assign empty     = (count_q == '0);
  assign full      = (count_q == CW'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R1

endmodule

// File: rtl/wrbuf_ctrl.sv
module wrbuf_ctrl #(
  parameter int AW = 30,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_read_first,
  input  logic          wr_valid,
  output logic          wr_ready,
  output logic          push,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  output logic [AW-1:0] look_addr,
  input  logic          buf_empty,
  input  logic          buf_full,
  input  logic          buf_hit,
  input  logic [DW-1:0] buf_hit_data,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  output logic          pop,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata,
  output logic          rd_resp_valid,
  output logic [DW-1:0] rd_resp_data
);
  import wrbuf_pkg::*;

  rd_state_e     state_q;
  logic [AW-1:0] rd_addr_q;
  logic          wpend_q;
  logic          resp_vld_q;
  logic [DW-1:0] resp_dat_q;

  // named events
  logic drain_ok, issue_rd, rd_fire, fwd_now, wr_stall;

  assign rd_ready  = (state_q == RS_IDLE);
  assign wr_ready  = (state_q == RS_IDLE) && !buf_full;
  assign push      = wr_valid && wr_ready;
  assign rd_fire   = rd_valid && rd_ready;
  assign look_addr = rd_addr_q;

  // a write left stalled on the port keeps its slot (handshake hold)
  assign drain_ok = (state_q == RS_IDLE) || (state_q == RS_DRAIN) || wpend_q;
  assign issue_rd = (state_q == RS_MEMRD) && !wpend_q;
  assign fwd_now  = (state_q == RS_CHECK) && cfg_read_first && buf_hit;

  assign mem_req_valid = issue_rd || (drain_ok && !buf_empty);
  assign mem_req_we    = !issue_rd;
  assign mem_req_addr  = issue_rd ? rd_addr_q : head_addr;
  assign mem_req_wdata = head_data;
  assign pop           = mem_req_valid && mem_req_we && mem_req_ready;
  assign wr_stall      = mem_req_valid && mem_req_we && !mem_req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= RS_IDLE;
      rd_addr_q  <= '0;
      wpend_q    <= 1'b0;
      resp_vld_q <= 1'b0;
      resp_dat_q <= '0;
    end else begin
      wpend_q    <= wr_stall;
      resp_vld_q <= 1'b0;
      case (state_q)
        RS_IDLE: if (rd_fire) begin
          rd_addr_q <= rd_addr;
          state_q   <= RS_CHECK;
        end
        RS_CHECK: begin
          if (fwd_now) begin
            resp_vld_q <= 1'b1;
            resp_dat_q <= buf_hit_data;
            state_q    <= RS_IDLE;
          end else if (cfg_read_first) begin
            state_q <= RS_MEMRD;
          end else begin
            state_q <= RS_DRAIN;
          end
        end
        RS_DRAIN: if (buf_empty) state_q <= RS_MEMRD;
        RS_MEMRD: if (issue_rd && mem_req_ready) state_q <= RS_MEMWAIT;
        RS_MEMWAIT: if (mem_rsp_valid) begin
          resp_vld_q <= 1'b1;
          resp_dat_q <= mem_rsp_rdata;
          state_q    <= RS_IDLE;
        end
        default: state_q <= RS_IDLE;
      endcase
    end
  end

  assign rd_resp_valid = resp_vld_q;
  assign rd_resp_data  = resp_dat_q;

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_MEMWAIT) |-> !mem_req_valid); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we))); // R9
  AST_FWD_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_now |=> (state_q == RS_IDLE) && rd_resp_valid); // R5

endmodule

// File: rtl/wrbuf_bypass.sv
module wrbuf_bypass #(
  parameter int DEPTH = 4,
  parameter int AW    = 30,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_read_first,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_resp_valid,
  output logic [DW-1:0] rd_resp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata
);

  logic          push, pop, buf_empty, buf_full, buf_hit;
  logic [AW-1:0] look_addr, head_addr;
  logic [DW-1:0] buf_hit_data, head_data;

  wrbuf_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_addr(wr_addr), .push_data(wr_data),
    .pop(pop), .look_addr(look_addr),
    .hit(buf_hit), .hit_data(buf_hit_data),
    .head_addr(head_addr), .head_data(head_data),
    .empty(buf_empty), .full(buf_full)
  );

  wrbuf_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_read_first(cfg_read_first),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .push(push),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .look_addr(look_addr),
    .buf_empty(buf_empty), .buf_full(buf_full),
    .buf_hit(buf_hit), .buf_hit_data(buf_hit_data),
    .head_addr(head_addr), .head_data(head_data), .pop(pop),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data)
  );

  AST_WPRIO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_we && !cfg_read_first) |-> buf_empty); // R6
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !wr_ready); // R4
  AST_READ_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ready |-> !wr_ready); // R7

endmodule

// File: tb/wrbuf_bypass_tb.sv
module wrbuf_bypass_tb;
  localparam int DEPTH = 4;
  localparam int AW    = 30;
  localparam int DW    = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic          rst_n, cfg_read_first;
  logic          wr_valid, wr_ready, rd_valid, rd_ready;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data;
  logic          rd_resp_valid;
  logic [DW-1:0] rd_resp_data;
  logic          mem_req_valid, mem_req_ready, mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid;
  logic [DW-1:0] mem_rsp_rdata;
  logic          mem_stall;

  assign mem_req_ready = !mem_stall;

  wrbuf_bypass #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_read_first(cfg_read_first),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] shadow [int];
  logic [DW-1:0] memm   [int];
  logic [DW-1:0] exp_rd_q [$];
  logic [AW-1:0] exp_wa_q [$];
  logic [DW-1:0] exp_wd_q [$];
  bit            log_we [$];
  int            n_mem_reads = 0;

  int            rsp_cnt = 0;
  logic [DW-1:0] rsp_data;
  bit            read_out = 0;
  bit            viol = 0;
  bit            prev_stall = 0;
  logic [AW-1:0] prev_addr;
  logic          prev_we;

  function automatic logic [DW-1:0] dflt(input int a);
    return DW'(a) ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // driver: write, expected memory write pushed to scoreboard
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    shadow[int'(a)] = d;
    exp_wa_q.push_back(a);
    exp_wd_q.push_back(d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // driver: read miss; expected value is the latest value written
  task automatic do_read(input logic [AW-1:0] a);
    @(negedge clk);
    while (!rd_ready) @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    exp_rd_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : dflt(int'(a)));
    @(negedge clk);
    rd_valid = 1'b0;
    // R7: read now pending
    chk("R7", "wr_ready while read pending", {31'b0, wr_ready}, 32'd0);
    chk("R7", "rd_ready while read pending", {31'b0, rd_ready}, 32'd0);
  endtask

  // memory model and memory-side monitor
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (rst_n && prev_stall) begin
      // R9: stalled request held
      chk("R9", "held valid", {31'b0, mem_req_valid}, 32'd1);
      chk("R9", "held addr", DW'(mem_req_addr), DW'(prev_addr));
      chk("R9", "held we", {31'b0, mem_req_we}, {31'b0, prev_we});
    end
    if (read_out && mem_req_valid) viol = 1;
    if (rsp_cnt > 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = rsp_data;
        read_out = 0;
        chk("R8", "request while read outstanding", {31'b0, viol}, 32'd0);
        viol = 0;
      end
    end
    if (rst_n && mem_req_valid && mem_req_ready) begin
      log_we.push_back(mem_req_we);
      if (mem_req_we) begin
        memm[int'(mem_req_addr)] = mem_req_wdata;
        if (exp_wa_q.size() == 0) begin
          chk("R1", "unexpected memory write", 32'd1, 32'd0);
        end else begin
          // R1 order / R2 no merge
          chk("R1", "write addr order", DW'(mem_req_addr), DW'(exp_wa_q.pop_front()));
          chk("R2", "write data", mem_req_wdata, exp_wd_q.pop_front());
        end
      end else begin
        n_mem_reads++;
        read_out = 1;
        rsp_cnt  = 3;
        rsp_data = memm.exists(int'(mem_req_addr)) ? memm[int'(mem_req_addr)]
                                                  : dflt(int'(mem_req_addr));
      end
    end
    prev_stall = rst_n && mem_req_valid && !mem_req_ready;
    prev_addr  = mem_req_addr;
    prev_we    = mem_req_we;
  end

  // response monitor (scoreboard pop)
  always @(negedge clk) begin
    if (rst_n && rd_resp_valid) begin
      if (exp_rd_q.size() == 0) chk("R5", "unexpected read response", 32'd1, 32'd0);
      else chk("R5/R6", "read data", rd_resp_data, exp_rd_q.pop_front());
    end
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_read_first = 1'b1; mem_stall = 1'b0;
    wr_valid = 1'b0; rd_valid = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    mem_rsp_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "wr_ready", {31'b0, wr_ready}, 32'd1);
    chk("R10", "rd_ready", {31'b0, rd_ready}, 32'd1);
    chk("R10", "mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
    chk("R10", "rd_resp_valid", {31'b0, rd_resp_valid}, 32'd0);

    // R1: stream of distinct addresses, memory always ready
    log_we.delete();
    for (int i = 0; i < 5; i++) do_write(AW'(16 + i), 32'h1000_0000 + i);
    settle(10);
    chk("R1", "all writes drained", exp_wa_q.size(), 32'd0);
    chk("R1", "memory write count", log_we.size(), 32'd5);

    // R2: repeated address not merged
    log_we.delete();
    do_write(AW'(40), 32'hAAAA_0001);
    do_write(AW'(40), 32'hAAAA_0002);
    settle(8);
    chk("R2", "two memory writes", log_we.size(), 32'd2);

    // R4: fill while memory stalls
    log_we.delete();
    mem_stall = 1'b1;
    for (int i = 0; i < DEPTH; i++) do_write(AW'(64 + i), 32'hB000_0000 + i);
    @(negedge clk);
    chk("R4", "wr_ready when full", {31'b0, wr_ready}, 32'd0);

    // R3: read-first, no match, bypasses queued writes
    do_read(AW'(200));
    settle(3);
    mem_stall = 1'b0;
    settle(25);
    chk("R3", "memory ops", log_we.size(), 32'd5);
    if (log_we.size() == 5) begin
      chk("R3", "op0 is stalled write", {31'b0, log_we[0]}, 32'd1);
      chk("R3", "op1 is read", {31'b0, log_we[1]}, 32'd0);
      chk("R3", "op4 is write", {31'b0, log_we[4]}, 32'd1);
    end
    chk("R3", "read answered", exp_rd_q.size(), 32'd0);

    // R5: read-first with match, youngest forwarded, memory untouched
    mem_stall = 1'b1;
    begin
      int reads_before;
      reads_before = n_mem_reads;
      do_write(AW'(300), 32'hC000_0001);
      do_write(AW'(300), 32'hC000_0002);
      do_write(AW'(301), 32'hC000_0003);
      do_read(AW'(300));
      settle(4);
      chk("R5", "forwarded while memory stalled", exp_rd_q.size(), 32'd0);
      chk("R5", "no memory read", n_mem_reads - reads_before, 32'd0);
    end
    mem_stall = 1'b0;
    settle(12);

    // R6: drain-first, read waits for all writes
    cfg_read_first = 1'b0;
    log_we.delete();
    mem_stall = 1'b1;
    do_write(AW'(400), 32'hD000_0001);
    do_write(AW'(401), 32'hD000_0002);
    do_write(AW'(400), 32'hD000_0003);
    do_read(AW'(400));
    settle(4);
    chk("R6", "no response before drain", exp_rd_q.size(), 32'd1);
    mem_stall = 1'b0;
    settle(25);
    chk("R6", "memory ops", log_we.size(), 32'd4);
    if (log_we.size() == 4) begin
      chk("R6", "op2 is write", {31'b0, log_we[2]}, 32'd1);
      chk("R6", "op3 is read", {31'b0, log_we[3]}, 32'd0);
    end
    chk("R6", "read answered", exp_rd_q.size(), 32'd0);

    // R6: drain-first with empty buffer, untouched address
    do_read(AW'(777));
    settle(12);
    chk("R6", "empty-buffer read answered", exp_rd_q.size(), 32'd0);

    // R3: read-first miss to an address already in memory
    cfg_read_first = 1'b1;
    do_read(AW'(16));
    settle(12);
    chk("R3", "miss read answered", exp_rd_q.size(), 32'd0);

    finish_run();
  end

endmodule